// File: doc/BRIEF.md
# Round-Robin Converter Scan Master

This block runs on a fast system clock and drives a four-wire serial link to an eight-input, 12-bit sampling converter. It divides the system clock down to a serial clock and frames each conversion with an active-low select. During each frame it sends the next channel address and collects the 12-bit result of the previous one. An eight-bit mask chooses the inputs that are visited. The block walks through the enabled inputs in ascending order, either without a break or in fixed-length bursts. Between bursts the select line is released so the converter can power down.

The converter always answers one frame late. The first frame after select falls returns input 0 whatever address is sent in it. The scan master keeps its own record of this pipeline, so every result leaves on `res_data` with the correct input number on `res_chan`. The result port is a valid-only stream. The converter cannot be paused once a frame has started, so there is no ready input and no back-pressure. A consumer must take `res_valid` in the cycle it is high, and a result that is not taken is lost. `scan_en`, `cont_mode` and `chan_mask` are plain level controls.

Top module: `conv_scan_master`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `cs_n` and `sclk` are 1 and `mosi` and `res_valid` are 0.
- R2: One serial clock period is 2*HALF_DIV system cycles. `sclk` is high whenever `cs_n` is high. The first falling edge comes HALF_DIV cycles after `cs_n` falls, and `cs_n` falls one cycle after the block samples `scan_en` high.
- R3: A frame is exactly 16 serial clock periods. In continuous mode the frames follow one another with no gap, so results arrive every 32*HALF_DIV cycles.
- R4: `mosi` changes only while `sclk` is low or idle. On rising edges 3, 4 and 5 of a frame it carries channel address bits 2, 1 and 0. On every other rising edge it is 0.
- R5: `miso` is sampled on each rising edge. The bits from rising edges 1 to 4 are dropped. The bits from rising edges 5 to 16 form `res_data`, most significant bit first.
- R6: `res_valid` is high for exactly one cycle: the cycle in which `sclk` rises for the 16th time in a frame, while `cs_n` is still low.
- R7: The first result after each fall of `cs_n` carries `res_chan` = 0. Every later result carries the address that was sent in the frame before it.
- R8: The addresses sent follow the enabled channels in ascending order and wrap from 7 to the lowest enabled channel. A channel whose bit in `chan_mask` is 0 is never addressed. After reset the walk starts at the lowest enabled channel.
- R9: With `chan_mask` all zero, `cs_n` stays high and no result is produced.
- R10: Dropping `scan_en` never cuts a frame short. The frame in progress completes and delivers its result, and `cs_n` rises HALF_DIV cycles after that result.
- R11: With `cont_mode` = 0, each burst has BURST_FRAMES frames and is followed by GAP_CYCLES cycles with `cs_n` high. The first address of the next burst is the enabled channel after the last one converted, so the address sent in the unanswered final frame is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Level: scan while high; a low level is acted on only at a frame boundary |
| cont_mode | input | 1 | 1 = frames back to back; 0 = bursts separated by a deselected gap |
| chan_mask | input | 8 | Bit n set enables converter input n |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low converter select |
| mosi | output | 1 | Serial address data to the converter |
| miso | input | 1 | Serial result data from the converter |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| res_data | output | 12 | Conversion result, straight binary |
| res_chan | output | 3 | Input number the result belongs to |

## Verification
With the bench settings (HALF_DIV = 2), `cs_n` falls one cycle after `scan_en` is seen high. The first `sclk` fall follows 2 cycles later, and the first `res_valid` comes 64 cycles after `cs_n` falls. Each further result in continuous mode is 64 cycles after the one before it. `cs_n` rises 2 cycles after the last result, and a burst gap lasts exactly GAP_CYCLES. A monitor takes a cycle stamp of every result and every select edge on the falling system-clock edge. The checks compare differences of these stamps, so they do not depend on process order. A converter model in the bench decodes the address bits and answers one frame late. It drives ones in the leading positions, so tags, data and dropped bits are all checked against values the bench works out for itself.

// File: rtl/cscan_pkg.sv
package cscan_pkg;
  localparam int NCH        = 8;
  localparam int CW         = $clog2(NCH);
  localparam int RES_W      = 12;
  localparam int FRAME_CLKS = 16;
  localparam int EDGES      = 2 * FRAME_CLKS;
  localparam int EW         = $clog2(EDGES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP
  } scan_state_e;
endpackage

// File: rtl/cscan_tick.sv
module cscan_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int DW = $clog2(HALF_DIV + 1);

  logic [DW-1:0] div_q;

  assign tick = run && (div_q == DW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           div_q <= '0;
    else if (!run || tick) div_q <= '0;
    else                  div_q <= div_q + 1'b1;
  end

  // R2: consecutive serial edges are never closer than two system cycles
  p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cscan_next.sv
module cscan_next #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  cur,
  output logic [CW-1:0]  nxt
);
  logic          found;
  logic [CW-1:0] idx;

  // first enabled channel strictly after cur, wrapping; cur itself is checked last
  always_comb begin
    nxt   = cur;
    found = 1'b0;
    idx   = cur;
    for (int k = 1; k <= NCH; k++) begin
      idx = cur + CW'(k);
      if (!found && mask[idx]) begin
        nxt   = idx;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cscan_rx.sv
module cscan_rx #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample,
  input  logic             sdi,
  output logic [RES_W-1:0] word_next
);
  logic [RES_W-2:0] sreg;

  assign word_next = {sreg, sdi};

  always_ff @(posedge clk) begin
    if (!rst_n)      sreg <= '0;
    else if (sample) sreg <= word_next[RES_W-2:0];
  end
endmodule

// File: rtl/conv_scan_master.sv
module conv_scan_master
  import cscan_pkg::*;
#(
  parameter int HALF_DIV     = 2,
  parameter int BURST_FRAMES = 4,
  parameter int GAP_CYCLES   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scan_en,
  input  logic        cont_mode,
  input  logic [7:0]  chan_mask,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso,
  output logic        res_valid,
  output logic [11:0] res_data,
  output logic [2:0]  res_chan
);
  localparam int FCW = $clog2(BURST_FRAMES + 1);
  localparam int GCW = $clog2(GAP_CYCLES + 1);

  scan_state_e      state_q;
  logic             tick, rise_tick;
  logic [EW-1:0]    edge_q;
  logic             fresh_q, first_q;
  logic [CW-1:0]    addr_q, tag_q, last_q;
  logic [CW-1:0]    nxt_from_last, nxt_from_addr;
  logic [FCW-1:0]   fcnt_q;
  logic [GCW-1:0]   gcnt_q;
  logic             sclk_q, cs_q, mosi_q, valid_q;
  logic [RES_W-1:0] data_q, word;
  logic [CW-1:0]    chan_q;
  logic             start_ok, cont_ok, tx_bit;
  logic [7:0]       tx_byte;

  cscan_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_RUN), .tick(tick));

  cscan_next #(.NCH(NCH)) u_next_last (
    .mask(chan_mask), .cur(last_q), .nxt(nxt_from_last));

  cscan_next #(.NCH(NCH)) u_next_addr (
    .mask(chan_mask), .cur(addr_q), .nxt(nxt_from_addr));

  assign rise_tick = tick && !sclk_q;

  cscan_rx #(.RES_W(RES_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sample(rise_tick), .sdi(miso), .word_next(word));

  assign start_ok = scan_en && (|chan_mask);
  assign cont_ok  = start_ok && (cont_mode || fcnt_q != FCW'(BURST_FRAMES - 1));

  // address byte: code in bits 5:3, rest zero, sent MSB first on rising edges 1..8
  assign tx_byte = {2'b00, addr_q, 3'b000};
  assign tx_bit  = edge_q[EW-1] ? 1'b0 : tx_byte[3'd7 - edge_q[3:1]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      mosi_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= '0;
      edge_q  <= '0;
      fresh_q <= 1'b0;
      first_q <= 1'b0;
      addr_q  <= '0;
      tag_q   <= '0;
      last_q  <= CW'(NCH - 1);
      fcnt_q  <= '0;
      gcnt_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_GAP: begin
          if (state_q == ST_GAP && !start_ok) begin
            state_q <= ST_IDLE;
          end else if (start_ok &&
                       (state_q == ST_IDLE || gcnt_q == GCW'(GAP_CYCLES - 1))) begin
            state_q <= ST_RUN;
            cs_q    <= 1'b0;
            mosi_q  <= 1'b0;
            edge_q  <= '0;
            fresh_q <= 1'b1;
            first_q <= 1'b1;
            tag_q   <= '0;
            addr_q  <= nxt_from_last;
            fcnt_q  <= '0;
          end else if (state_q == ST_GAP) begin
            gcnt_q <= gcnt_q + 1'b1;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (sclk_q) begin
              if (edge_q == '0 && !fresh_q) begin
                // frame boundary: continue or release select
                if (cont_ok) begin
                  sclk_q  <= 1'b0;
                  mosi_q  <= 1'b0;
                  edge_q  <= EW'(1);
                  tag_q   <= addr_q;
                  addr_q  <= nxt_from_addr;
                  first_q <= 1'b0;
                  fcnt_q  <= cont_mode ? '0 : fcnt_q + 1'b1;
                end else begin
                  cs_q    <= 1'b1;
                  edge_q  <= '0;
                  gcnt_q  <= '0;
                  state_q <= (start_ok && !cont_mode) ? ST_GAP : ST_IDLE;
                end
              end else begin
                sclk_q  <= 1'b0;
                mosi_q  <= tx_bit;
                edge_q  <= edge_q + 1'b1;
                fresh_q <= 1'b0;
              end
            end else begin
              sclk_q <= 1'b1;
              edge_q <= edge_q + 1'b1;
              if (edge_q == EW'(EDGES - 1)) begin
                valid_q <= 1'b1;
                data_q  <= word;
                chan_q  <= tag_q;
                if (!first_q) last_q <= tag_q;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign mosi      = mosi_q;
  assign res_valid = valid_q;
  assign res_data  = data_q;
  assign res_chan  = chan_q;

  // R2: serial clock parked high while deselected
  p_sclk_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);
  // R4: data line never moves at a rising serial edge
  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi_q));
  // R6: result strobe lasts one cycle
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  // R6: result strobe coincides with a rising edge inside a frame
  p_valid_on_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($rose(sclk_q) && !cs_q));
  // R7: priming frame result is tagged input 0
  p_first_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && first_q) |-> (chan_q == '0));
  // R9: empty mask keeps select released
  p_mask_zero_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && chan_mask == 8'h00) |=> cs_q);
endmodule

// File: tb/conv_scan_master_test.sv
module conv_scan_master_test;
  localparam int H      = 2;
  localparam int BF     = 4;
  localparam int GAP    = 16;
  localparam int FR_CYC = 32 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic        cont_mode = 1'b1;
  logic [7:0]  chan_mask = 8'h00;
  logic        sclk, cs_n, mosi;
  logic        miso = 1'b0;
  logic        res_valid;
  logic [11:0] res_data;
  logic [2:0]  res_chan;

  conv_scan_master #(.HALF_DIV(H), .BURST_FRAMES(BF), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .cont_mode(cont_mode),
    .chan_mask(chan_mask), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan));

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;

  function automatic logic [11:0] mdata(input logic [2:0] c);
    return {c, ~c, 6'b101101};
  endfunction

  // converter model: answers one frame late, ones in leading positions
  int fc = 0, rc = 0;
  logic [2:0] m_sh = 3'd0, m_cur = 3'd0;
  logic mosi_bad = 1'b0;
  always @(negedge cs_n) begin fc = 0; rc = 0; m_cur = 3'd0; end
  always @(negedge sclk) if (cs_n === 1'b0) begin
    int pos;
    logic [11:0] w;
    pos = fc % 16 + 1;
    w = mdata(m_cur);
    miso <= (pos <= 4) ? 1'b1 : w[16 - pos];
    fc++;
  end
  always @(posedge sclk) if (cs_n === 1'b0) begin
    int pos;
    pos = rc % 16 + 1;
    if (pos >= 3 && pos <= 5) m_sh = {m_sh[1:0], mosi};
    else if (mosi) mosi_bad = 1'b1;
    if (pos == 16) m_cur = m_sh;
    rc++;
  end

  // monitor, sampled away from the active edge
  logic [2:0]  got_ch [0:15];
  logic [11:0] got_d  [0:15];
  int got_t [0:15];
  int fall_t [0:7];
  int rise_t [0:7];
  int nres = 0, n_fall = 0, n_rise = 0, t_sfall1 = 0;
  bit wait_sf = 0, vbad = 0;
  logic sclk_prev = 1'b1, cs_prev = 1'b1;
  always @(negedge clk) begin
    if (res_valid === 1'b1) begin
      if (nres < 16) begin
        got_ch[nres] = res_chan; got_d[nres] = res_data; got_t[nres] = cyc;
      end
      nres++;
      if (!(sclk === 1'b1 && sclk_prev === 1'b0 && cs_n === 1'b0)) vbad = 1;
    end
    if (cs_n === 1'b0 && cs_prev === 1'b1) begin
      if (n_fall < 8) fall_t[n_fall] = cyc;
      n_fall++; wait_sf = 1;
    end
    if (cs_n === 1'b1 && cs_prev === 1'b0) begin
      if (n_rise < 8) rise_t[n_rise] = cyc;
      n_rise++;
    end
    if (wait_sf && sclk === 1'b0 && sclk_prev === 1'b1) begin
      t_sfall1 = cyc; wait_sf = 0;
    end
    sclk_prev = sclk; cs_prev = cs_n;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    scan_en = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    nres = 0; n_fall = 0; n_rise = 0; vbad = 0; wait_sf = 0;
    rst_n = 1'b1;
  endtask

  task automatic wait_res(input int n, input int limit);
    for (int i = 0; i < limit && nres < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && cs_n !== 1'b1; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // mask, then expected tags of the first five results
  localparam logic [22:0] VEC [0:4] = '{
    {8'hFF, 3'd0, 3'd0, 3'd1, 3'd2, 3'd3},
    {8'hA4, 3'd0, 3'd2, 3'd5, 3'd7, 3'd2},
    {8'h80, 3'd0, 3'd7, 3'd7, 3'd7, 3'd7},
    {8'h01, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0},
    {8'h18, 3'd0, 3'd3, 3'd4, 3'd3, 3'd4}
  };

  bit done = 0;

  task automatic report();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) if (!done && cyc > 150000) begin
    n_chk++; n_bad++;
    $display("FAIL watchdog R3 actual=%0d expected=finished", cyc);
    done = 1;
    report();
  end

  initial begin
    int t_en;
    logic [2:0] exp_ch;
    // R1: reset state
    do_reset();
    @(negedge clk);
    chk("R1 cs_n", int'(cs_n), 1);
    chk("R1 sclk", int'(sclk), 1);
    chk("R1 mosi", int'(mosi), 0);
    chk("R1 res_valid", int'(res_valid), 0);

    // vector walk: continuous scans with different masks
    for (int v = 0; v < 5; v++) begin
      do_reset();
      cont_mode = 1'b1;
      chan_mask = VEC[v][22:15];
      @(negedge clk);
      scan_en = 1'b1; t_en = cyc;
      wait_res(5, 2000);
      scan_en = 1'b0;
      wait_idle(400);
      chk("R10 result count after stop", nres, 5);
      for (int k = 0; k < 5; k++) begin
        exp_ch = VEC[v][14 - 3*k -: 3];
        chk($sformatf("R7 R8 tag v%0d k%0d", v, k), int'(got_ch[k]), int'(exp_ch));
        chk($sformatf("R5 data v%0d k%0d", v, k), int'(got_d[k]), int'(mdata(exp_ch)));
        if (k > 0) chk("R3 result spacing", got_t[k] - got_t[k-1], FR_CYC);
      end
      if (v == 0) begin
        chk("R2 select delay", fall_t[0] - t_en, 1);
        chk("R2 first sclk fall", t_sfall1 - fall_t[0], H);
        chk("R6 first result delay", got_t[0] - fall_t[0], FR_CYC);
        chk("R10 select release delay", rise_t[0] - got_t[4], H);
      end
    end
    chk("R4 stray mosi bits", int'(mosi_bad), 0);
    chk("R6 strobe placement", int'(vbad), 0);

    // R9: empty mask never selects
    do_reset();
    chan_mask = 8'h00; cont_mode = 1'b1;
    @(negedge clk) scan_en = 1'b1;
    repeat (300) @(negedge clk);
    chk("R9 select falls", n_fall, 0);
    chk("R9 results", nres, 0);
    scan_en = 1'b0;

    // R10: stop requested mid-frame
    do_reset();
    chan_mask = 8'hFF; cont_mode = 1'b1;
    @(negedge clk) scan_en = 1'b1;
    wait_res(2, 2000);
    repeat (10) @(negedge clk);
    scan_en = 1'b0;
    wait_idle(400);
    chk("R10 mid-frame stop count", nres, 3);
    chk("R10 mid-frame release", rise_t[0] - got_t[2], H);

    // R11: bursts with gap and resent address
    do_reset();
    chan_mask = 8'hFF; cont_mode = 1'b0;
    @(negedge clk) scan_en = 1'b1;
    wait_res(8, 4000);
    scan_en = 1'b0;
    wait_idle(400);
    for (int k = 0; k < 8; k++) begin
      exp_ch = (k < 4) ? ((k == 0) ? 3'd0 : 3'(k - 1)) : ((k == 4) ? 3'd0 : 3'(k - 2));
      chk($sformatf("R11 burst tag k%0d", k), int'(got_ch[k]), int'(exp_ch));
    end
    chk("R11 burst end", rise_t[0] - got_t[BF-1], H);
    chk("R11 gap length", fall_t[1] - rise_t[0], GAP);
    chk("R11 burst count", n_fall, 2);

    done = 1;
    report();
  end
endmodule